// File: doc/BRIEF.md
# Dual-Channel Indexed Register Port with Clock-Measurement Counter

This block is the byte-wide configuration space of a two-channel disk controller. Each channel has a small index/data window on the host bus. The host first writes a register number into the channel's index port. It then reads or writes that register through the channel's data port. Behind the two windows sit the following registers:

- a control byte in each channel;
- the PLL divider settings, in the second channel;
- a read-only cable-sense status byte in each channel;
- sixteen per-drive timing bytes in each channel.

A 30-bit down counter also sits behind the windows. It is used to measure a clock. Software sets a run bit in the first channel's control byte and lets the counter fall for a known time. It then clears the run bit and reads the frozen value back in four slices spread over the two channels' index spaces. The 8-bit slices hold counter bits 7:0 and 22:15. The 7-bit slices hold bits 14:8 and 29:23, and read with a zero in data bit 7. The count tick is a single-cycle enable input that stands in for the reference clock. The divider values are also driven out as ports toward the PLL.

Top module: `regidx_port`

## Requirements
- R1: Bus offset 1 is channel A's index port and offset 3 its data port; offsets 9 and 11 are the same for channel B. An index port reads back the last index written to it. Every other offset reads 0x00, and writes to it have no effect.
- R2: `bus_rdata` is registered. It takes the addressed value at the clock edge that samples `bus_rd` and holds it until the next read. After reset, `bus_rdata` and both index registers are 0x00.
- R3: The measurement counter is 30 bits wide and resets to 0x3FFFFFFF. It decreases by exactly one at each edge where `cnt_tick` is 1 and the run bit was already 1 before that edge.
- R4: The run bit is bit 6 of channel A index 0x01. While it is 0, the counter holds its value whatever `cnt_tick` does.
- R5: The counter reads through four slices. Channel A index 0x20 gives counter bits 7:0. Channel A index 0x21 gives {0, bits 14:8}. Channel B index 0x20 gives bits 22:15. Channel B index 0x21 gives {0, bits 29:23}. Writes to these indices are ignored.
- R6: Index 0x01 of each channel is a full 8-bit read/write control byte that resets to 0x00. All of its bits hold the values written to them.
- R7: Channel B index 0x02 holds a 7-bit feedback divider. Bit 7 is dropped on a write and reads as 0. Channel B index 0x03 holds an 8-bit reference divider. Both reset to 0 and appear on `pll_fb_div` and `pll_ref_div` from the edge that writes them.
- R8: Index 0x0b of each channel reads {5'b0, cable_40w[ch], 2'b0}, where 1 means a 40-wire cable and 0 means an 80-wire cable. Writes to it are ignored.
- R9: Indices 0x0c to 0x13 are drive 0's timing bytes, and 0x14 to 0x1b are drive 1's, each at drive 0's index plus 8. They are 8-bit read/write, reset to 0x00, and are separate for each channel. Bit 7 of 0x10 and 0x18 can be cleared by a byte write without changing the other bits.
- R10: Any index not listed above reads 0x00 and ignores writes. This includes indices 0x02 and 0x03 on channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset within the two channel windows |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_tick | input | 1 | Count-enable tick for the measurement counter |
| cable_40w | input | 2 | Cable sense per channel, 1 = 40-wire |
| pll_fb_div | output | 7 | Feedback divider setting |
| pll_ref_div | output | 8 | Reference divider setting |

## Verification
A write to an index port, a register or a divider takes effect at the rising edge that samples the strobe. A read result appears on `bus_rdata` after that same edge, so it is due one cycle after the strobe is driven. A run-bit change governs ticks from the following edge onward. The bench drives inputs on falling edges and updates its reference model at each rising edge from the values present before that edge. It then compares `bus_rdata` and the divider outputs at the next falling edge, which is exactly where each result is due. Directed reads of the frozen counter slices check hand-computed values after 1,000 ticks and after 41,000 ticks, and a tick burst with the run bit clear checks the freeze.

// File: rtl/regidx_pkg.sv
// Package: shared constants and types for the indexed register port.
// Assumes two channels whose windows sit PORT_STRIDE bytes apart.
package regidx_pkg;
    localparam int BYTE_W      = 8;
    localparam int NUM_CH      = 2;
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int PORT_STRIDE = 8;
    localparam int OFS_INDEX   = 1;
    localparam int OFS_DATA    = 3;

    localparam logic [BYTE_W-1:0] IDX_CTRL     = 8'h01;
    localparam logic [BYTE_W-1:0] IDX_PLL_F    = 8'h02;
    localparam logic [BYTE_W-1:0] IDX_PLL_R    = 8'h03;
    localparam logic [BYTE_W-1:0] IDX_STATUS   = 8'h0b;
    localparam logic [BYTE_W-1:0] IDX_TIM_BASE = 8'h0c;
    localparam logic [BYTE_W-1:0] IDX_CNT_LO   = 8'h20;
    localparam logic [BYTE_W-1:0] IDX_CNT_HI   = 8'h21;

    localparam int DRIVES      = 2;
    localparam int TIM_PER_DRV = 8;
    localparam int NUM_TIM     = DRIVES * TIM_PER_DRV;

    localparam int RUN_BIT   = 6;
    localparam int CABLE_BIT = 2;
    localparam int F_W       = 7;

    localparam int CNT_LO_W  = 8;
    localparam int CNT_HI_W  = 7;
    localparam int CH_CNT_W  = CNT_LO_W + CNT_HI_W;
    localparam int CNT_W     = NUM_CH * CH_CNT_W;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_sel_e;
endpackage

// File: rtl/regidx_decode.sv
// Module: regidx_decode
// Splits a bus byte offset into a channel number and a port kind
// (index, data or none). Assumes PORT_STRIDE bytes per channel window.
module regidx_decode
    import regidx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output port_sel_e         sel
);
    // Purpose: derive channel and port kind from the offset.
    always_comb begin
        int unsigned a;
        int unsigned ofs;
        int unsigned chn;
        a   = 32'(addr);
        chn = a / PORT_STRIDE;
        ofs = a % PORT_STRIDE;
        ch  = CH_W'(chn);
        sel = PORT_NONE;
        if (chn < NUM_CH) begin
            if (ofs == OFS_INDEX)     sel = PORT_INDEX;
            else if (ofs == OFS_DATA) sel = PORT_DATA;
        end
    end
endmodule

// File: rtl/regidx_meas_counter.sv
// Module: regidx_meas_counter
// Free-running down counter for clock measurement. It resets to all
// ones and steps down once per tick while run is high. It wraps modulo 2^W.
module regidx_meas_counter #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Purpose: decrement on gated ticks, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '1;
        else if (run && tick) cnt <= cnt - ONE;
    end

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt == $past(cnt) - ONE)); // R3
endmodule

// File: rtl/regidx_channel.sv
// Module: regidx_channel
// One channel's index register and the registers it selects: control,
// status, per-drive timing and, optionally, the PLL dividers and the
// run bit. Assumes single-cycle write strobes already decoded per port.
module regidx_channel
    import regidx_pkg::*;
#(
    parameter bit HAS_PLL  = 1'b0,
    parameter bit OWNS_RUN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_we,
    input  logic                data_we,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                cable_40w,
    input  logic [CNT_LO_W-1:0] cnt_lo,
    input  logic [CNT_HI_W-1:0] cnt_hi,
    output logic [BYTE_W-1:0]   idx_q,
    output logic [BYTE_W-1:0]   rd_val,
    output logic                run,
    output logic [F_W-1:0]      pll_f,
    output logic [BYTE_W-1:0]   pll_r
);
    localparam int TIM_AW = $clog2(NUM_TIM);

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] tim_q [NUM_TIM];
    logic [BYTE_W-1:0] tim_off;
    logic              tim_hit;
    logic [TIM_AW-1:0] tim_sel;

    // Purpose: locate the index within the timing register bank.
    always_comb begin
        tim_off = idx_q - IDX_TIM_BASE;
        tim_hit = (idx_q >= IDX_TIM_BASE) && (tim_off[BYTE_W-1:TIM_AW] == '0);
        tim_sel = tim_off[TIM_AW-1:0];
    end

    // Purpose: index register, loaded by index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata;
    end

    // Purpose: control byte, all bits plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (data_we && idx_q == IDX_CTRL) ctrl_q <= wdata;
    end

    // Purpose: per-drive timing bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
        end else if (data_we && tim_hit) begin
            tim_q[tim_sel] <= wdata;
        end
    end

    generate
        if (HAS_PLL) begin : g_pll
            logic [F_W-1:0]    f_q;
            logic [BYTE_W-1:0] r_q;
            // Purpose: PLL divider registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    f_q <= '0;
                    r_q <= '0;
                end else if (data_we) begin
                    if (idx_q == IDX_PLL_F) f_q <= wdata[F_W-1:0];
                    if (idx_q == IDX_PLL_R) r_q <= wdata;
                end
            end
            assign pll_f = f_q;
            assign pll_r = r_q;
        end else begin : g_no_pll
            assign pll_f = '0;
            assign pll_r = '0;
        end

        if (OWNS_RUN) begin : g_run
            assign run = ctrl_q[RUN_BIT];
        end else begin : g_no_run
            assign run = 1'b0;
        end
    endgenerate

    // Purpose: read value of the register the index selects.
    always_comb begin
        rd_val = '0;
        if (idx_q == IDX_CTRL) begin
            rd_val = ctrl_q;
        end else if (HAS_PLL && idx_q == IDX_PLL_F) begin
            rd_val = {{(BYTE_W-F_W){1'b0}}, pll_f};
        end else if (HAS_PLL && idx_q == IDX_PLL_R) begin
            rd_val = pll_r;
        end else if (idx_q == IDX_STATUS) begin
            rd_val[CABLE_BIT] = cable_40w;
        end else if (tim_hit) begin
            rd_val = tim_q[tim_sel];
        end else if (idx_q == IDX_CNT_LO) begin
            rd_val = cnt_lo;
        end else if (idx_q == IDX_CNT_HI) begin
            rd_val = {{(BYTE_W-CNT_HI_W){1'b0}}, cnt_hi};
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(idx_q)); // R1
    AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && idx_q != IDX_CTRL) |=> $stable(ctrl_q)); // R10
    AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_STATUS) |-> (rd_val[7:3] == '0 && rd_val[1:0] == '0)); // R8
endmodule

// File: rtl/regidx_port.sv
// Module: regidx_port (top)
// Decodes the host bus into the per-channel index/data ports. It holds
// the measurement counter and spreads it in slices over the channels,
// and it registers the read data. Assumes at most one strobe per cycle.
module regidx_port
    import regidx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cnt_tick,
    input  logic [NUM_CH-1:0] cable_40w,
    output logic [F_W-1:0]    pll_fb_div,
    output logic [7:0]        pll_ref_div
);
    logic [CH_W-1:0]   dec_ch;
    port_sel_e         dec_sel;
    logic [CNT_W-1:0]  cnt;
    logic              meas_run;
    logic [BYTE_W-1:0] idx_arr  [NUM_CH];
    logic [BYTE_W-1:0] rd_arr   [NUM_CH];
    logic              run_arr  [NUM_CH];
    logic [F_W-1:0]    f_arr    [NUM_CH];
    logic [BYTE_W-1:0] r_arr    [NUM_CH];

    regidx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .ch   (dec_ch),
        .sel  (dec_sel)
    );

    regidx_meas_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (meas_run),
        .tick  (cnt_tick),
        .cnt   (cnt)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic idx_we;
            logic data_we;
            assign idx_we  = bus_wr && (dec_ch == CH_W'(g)) && (dec_sel == PORT_INDEX);
            assign data_we = bus_wr && (dec_ch == CH_W'(g)) && (dec_sel == PORT_DATA);

            regidx_channel #(
                .HAS_PLL  (g == NUM_CH - 1),
                .OWNS_RUN (g == 0)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .idx_we    (idx_we),
                .data_we   (data_we),
                .wdata     (bus_wdata),
                .cable_40w (cable_40w[g]),
                .cnt_lo    (cnt[g*CH_CNT_W +: CNT_LO_W]),
                .cnt_hi    (cnt[g*CH_CNT_W + CNT_LO_W +: CNT_HI_W]),
                .idx_q     (idx_arr[g]),
                .rd_val    (rd_arr[g]),
                .run       (run_arr[g]),
                .pll_f     (f_arr[g]),
                .pll_r     (r_arr[g])
            );
        end
    endgenerate

    // Purpose: merge per-channel outputs; channels without a function drive 0.
    always_comb begin
        meas_run    = 1'b0;
        pll_fb_div  = '0;
        pll_ref_div = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            meas_run    = meas_run | run_arr[i];
            pll_fb_div  = pll_fb_div | f_arr[i];
            pll_ref_div = pll_ref_div | r_arr[i];
        end
    end

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (dec_sel)
                PORT_INDEX: bus_rdata <= idx_arr[dec_ch];
                PORT_DATA:  bus_rdata <= rd_arr[dec_ch];
                default:    bus_rdata <= '0;
            endcase
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec_sel == PORT_NONE) |=> (bus_rdata == '0)); // R1
    AST_HI_SLICE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec_sel == PORT_DATA && idx_arr[dec_ch] == IDX_CNT_HI)
        |=> (bus_rdata[7] == 1'b0)); // R5
endmodule

// File: tb/regidx_port_test.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed reads with hand-computed expected values.
module regidx_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0;
    logic [1:0] cable_40w = 2'b01;
    logic [6:0] pll_fb_div;
    logic [7:0] pll_ref_div;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit live = 1'b0;

    always #4 clk = ~clk;

    regidx_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .cable_40w(cable_40w),
        .pll_fb_div(pll_fb_div), .pll_ref_div(pll_ref_div)
    );

    // reference model state
    logic [7:0]  m_reg [2][256];
    logic [7:0]  m_idx [2];
    logic [29:0] m_cnt;
    logic [7:0]  m_rdata;
    string       m_tag = "R2";
    logic        m_run_old;

    function automatic logic [7:0] m_lookup(int ch, logic [7:0] ix);
        if (ix == 8'h01) return m_reg[ch][ix];
        if (ch == 1 && (ix == 8'h02 || ix == 8'h03)) return m_reg[ch][ix];
        if (ix == 8'h0b) return {5'b0, cable_40w[ch], 2'b0};
        if (ix >= 8'h0c && ix <= 8'h1b) return m_reg[ch][ix];
        if (ix == 8'h20) return (ch == 0) ? m_cnt[7:0] : m_cnt[22:15];
        if (ix == 8'h21) return (ch == 0) ? {1'b0, m_cnt[14:8]} : {1'b0, m_cnt[29:23]};
        return 8'h00;
    endfunction

    function automatic string m_classify(logic [3:0] a);
        logic [7:0] ix;
        if (a != 4'd3 && a != 4'd11) return "R1";
        ix = m_idx[a == 4'd11];
        if (ix == 8'h01) return "R6";
        if (ix == 8'h0b) return "R8";
        if (ix >= 8'h0c && ix <= 8'h1b) return "R9";
        if (ix == 8'h20 || ix == 8'h21) return "R5";
        if (a == 4'd11 && (ix == 8'h02 || ix == 8'h03)) return "R7";
        return "R10";
    endfunction

    function automatic void m_write(logic [3:0] a, logic [7:0] d);
        int ch;
        logic [7:0] ix;
        if (a == 4'd1)  begin m_idx[0] = d; return; end
        if (a == 4'd9)  begin m_idx[1] = d; return; end
        if (a != 4'd3 && a != 4'd11) return;
        ch = (a == 4'd11) ? 1 : 0;
        ix = m_idx[ch];
        if (ix == 8'h01 || (ix >= 8'h0c && ix <= 8'h1b)) m_reg[ch][ix] = d;
        else if (ch == 1 && ix == 8'h02) m_reg[ch][ix] = d & 8'h7f;
        else if (ch == 1 && ix == 8'h03) m_reg[ch][ix] = d;
    endfunction

    // model step: uses the values present before the edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                for (int i = 0; i < 256; i++) m_reg[c][i] = 8'h00;
                m_idx[c] = 8'h00;
            end
            m_cnt = '1;
            m_rdata = 8'h00;
            m_tag = "R2";
        end else begin
            m_run_old = m_reg[0][1][6];
            if (bus_rd) begin
                m_tag = m_classify(bus_addr);
                if (bus_addr == 4'd1)       m_rdata = m_idx[0];
                else if (bus_addr == 4'd9)  m_rdata = m_idx[1];
                else if (bus_addr == 4'd3)  m_rdata = m_lookup(0, m_idx[0]);
                else if (bus_addr == 4'd11) m_rdata = m_lookup(1, m_idx[1]);
                else                        m_rdata = 8'h00;
            end
            if (bus_wr) m_write(bus_addr, bus_wdata);
            if (m_run_old && cnt_tick) m_cnt = m_cnt - 30'd1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            chk(bus_rdata === m_rdata, m_tag, 32'(bus_rdata), 32'(m_rdata));
            chk(pll_fb_div === m_reg[1][2][6:0], "R7", 32'(pll_fb_div), 32'(m_reg[1][2][6:0]));
            chk(pll_ref_div === m_reg[1][3], "R7", 32'(pll_ref_div), 32'(m_reg[1][3]));
        end
    end

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input int ch, input logic [7:0] ix, input logic [7:0] d);
        do_wr(ch ? 4'd9 : 4'd1, ix);
        do_wr(ch ? 4'd11 : 4'd3, d);
    endtask

    task automatic expect_reg(input int ch, input logic [7:0] ix, input logic [7:0] exp, input string tag);
        do_wr(ch ? 4'd9 : 4'd1, ix);
        do_rd(ch ? 4'd11 : 4'd3);
        chk(bus_rdata === exp, tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_tick = 1'b1;
        end
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic expect_count(input logic [29:0] v, input string tag);
        expect_reg(0, 8'h20, v[7:0], tag);
        expect_reg(0, 8'h21, {1'b0, v[14:8]}, tag);
        expect_reg(1, 8'h20, v[22:15], tag);
        expect_reg(1, 8'h21, {1'b0, v[29:23]}, tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        // R2: reset state of read data and index registers
        chk(bus_rdata === 8'h00, "R2", 32'(bus_rdata), 32'h0);
        do_rd(4'd1);
        chk(bus_rdata === 8'h00, "R2", 32'(bus_rdata), 32'h0);
        do_rd(4'd9);
        chk(bus_rdata === 8'h00, "R2", 32'(bus_rdata), 32'h0);
        // R3: counter reset value through all four slices
        expect_count(30'h3FFFFFFF, "R3");
        // R1: index port readback, unused offsets
        do_wr(4'd1, 8'h21);
        do_rd(4'd1);
        chk(bus_rdata === 8'h21, "R1", 32'(bus_rdata), 32'h21);
        do_wr(4'd5, 8'hAA);
        do_rd(4'd5);
        chk(bus_rdata === 8'h00, "R1", 32'(bus_rdata), 32'h0);
        do_rd(4'd1);
        chk(bus_rdata === 8'h21, "R1", 32'(bus_rdata), 32'h21);
        repeat (3) @(negedge clk);
        chk(bus_rdata === 8'h21, "R2", 32'(bus_rdata), 32'h21);
        // R6: control bytes keep every bit
        wr_reg(0, 8'h01, 8'hBF);
        expect_reg(0, 8'h01, 8'hBF, "R6");
        wr_reg(1, 8'h01, 8'h5A);
        expect_reg(1, 8'h01, 8'h5A, "R6");
        // R4: run bit clear, ticks ignored
        ticks(50);
        expect_count(30'h3FFFFFFF, "R4");
        // R3: 1000 counted ticks
        wr_reg(0, 8'h01, 8'h40);
        ticks(1000);
        wr_reg(0, 8'h01, 8'h00);
        expect_count(30'h3FFFFC17, "R3");
        ticks(200);
        expect_count(30'h3FFFFC17, "R4");
        // R5: 40000 more ticks cross into the upper slices
        wr_reg(0, 8'h01, 8'h40);
        ticks(40000);
        wr_reg(0, 8'h01, 8'h00);
        expect_count(30'h3FFF5FD7, "R5");
        // R5: writes to slices ignored
        wr_reg(0, 8'h20, 8'h00);
        wr_reg(1, 8'h21, 8'h00);
        expect_count(30'h3FFF5FD7, "R5");
        // R3: running while reading, compared by the model each cycle
        wr_reg(0, 8'h01, 8'h40);
        fork
            ticks(300);
            begin
                for (int k = 0; k < 10; k++) begin
                    do_rd(4'd3);
                    do_rd(4'd11);
                end
            end
        join
        wr_reg(0, 8'h01, 8'h00);
        // R7: divider registers
        wr_reg(1, 8'h02, 8'hFF);
        expect_reg(1, 8'h02, 8'h7F, "R7");
        chk(pll_fb_div === 7'h7F, "R7", 32'(pll_fb_div), 32'h7F);
        wr_reg(1, 8'h03, 8'h0D);
        expect_reg(1, 8'h03, 8'h0D, "R7");
        chk(pll_ref_div === 8'h0D, "R7", 32'(pll_ref_div), 32'h0D);
        // R10: channel A has no dividers; unmapped index ignored
        wr_reg(0, 8'h02, 8'h55);
        expect_reg(0, 8'h02, 8'h00, "R10");
        wr_reg(0, 8'h40, 8'h66);
        expect_reg(0, 8'h40, 8'h00, "R10");
        expect_reg(0, 8'h01, 8'h00, "R10");
        // R8: cable sense, writes ignored
        expect_reg(0, 8'h0b, 8'h04, "R8");
        expect_reg(1, 8'h0b, 8'h00, "R8");
        wr_reg(0, 8'h0b, 8'hFF);
        cable_40w = 2'b10;
        expect_reg(0, 8'h0b, 8'h00, "R8");
        expect_reg(1, 8'h0b, 8'h04, "R8");
        // R9: timing bytes per drive and per channel
        wr_reg(0, 8'h10, 8'hCD);
        wr_reg(1, 8'h18, 8'hCB);
        wr_reg(0, 8'h1b, 8'h25);
        expect_reg(0, 8'h10, 8'hCD, "R9");
        expect_reg(0, 8'h18, 8'h00, "R9");
        expect_reg(1, 8'h10, 8'h00, "R9");
        expect_reg(1, 8'h18, 8'hCB, "R9");
        expect_reg(0, 8'h1b, 8'h25, "R9");
        wr_reg(0, 8'h10, 8'h4D);
        expect_reg(0, 8'h10, 8'h4D, "R9");
        expect_reg(0, 8'h0c, 8'h00, "R9");
        expect_reg(0, 8'h1c, 8'h00, "R10");
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule